// File: doc/BRIEF.md
# Seven-Letter Candidate Block Generator

This block walks through every string of seven lowercase letters and, for each one, presents a complete single-block hash message (sixteen 32-bit words, already padded and length-tagged) to a downstream pipelined hash core. It presents one candidate per accepted clock cycle. The candidate string itself is presented next to the block, so that a later comparison stage can report which string produced a matching digest.

A one-cycle `start` pulse, given while the generator is idle, loads the all-'a' candidate. From then on, each clock edge on which `take` is high while `blk_valid` is high consumes the current candidate and moves to the next. The order works like an odometer. When the last candidate has been consumed, the generator drops `blk_valid` and raises `done`. The length, the alphabet size and the first character are parameters. Because the length is fixed, the padding byte, the zero words and the length word are all constants. Only the bytes that hold characters change from one candidate to the next.

Top module: `pwgen_top`

## Requirements
- R1: After reset, `blk_valid` is low, `done` is low and the held candidate is all 'a'.
- R2: A `start` pulse while `blk_valid` is low makes `blk_valid` high on the next cycle, with the candidate "aaaaaaa" and `done` cleared.
- R3: Each edge with `take` and `blk_valid` high advances the candidate. The last character (index 6) changes fastest. A position at 'z' wraps to 'a' and carries one step into the position before it.
- R4: While `blk_valid` is high and `take` is low, the candidate and `blk_valid` hold.
- R5: Message byte b sits at `blk_data[8b+7:8b]`, so word w is `blk_data[32w+31:32w]` in little-endian byte order. Bytes 0..6 are the characters, byte 7 is 0x80, word 14 is 56 (bytes 56..63 carry the 64-bit bit length), and every other byte is zero.
- R6: `cand[8i+7:8i]` holds character i, with character 0 first in the string.
- R7: Exactly ALPHA^NCHARS candidates are emitted. When "zzzzzzz" is consumed, `blk_valid` falls and `done` rises on the next cycle, and `done` stays high until the next accepted `start`.
- R8: `start` while `blk_valid` is high is ignored.
- R9: `take` while idle has no effect: nothing is emitted and the candidate does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an enumeration when idle |
| take | input | 1 | Downstream consumes the current candidate |
| blk_valid | output | 1 | `blk_data` and `cand` hold a live candidate |
| blk_data | output | 512 | Padded message block |
| cand | output | 8*NCHARS | Candidate string |
| done | output | 1 | Enumeration finished |

## Verification
Assertions check on every cycle the properties that relate one cycle to the next. These are: hold under a low `take`, holding while idle, a `start` that is ignored during a run, the all-'a' load, and the fact that `done` rises only right after the final string is consumed. Some behaviour can only be shown by scenarios. This covers the exact odometer order across carries, the byte layout of the block and the candidate count at completion. The bench compares all outputs against a behavioural model. For the full count it runs a shrunken instance (three letters from a three-symbol alphabet).

// File: rtl/pwgen_pkg.sv
package pwgen_pkg;
    typedef struct packed {
        logic running;
        logic done;
    } pwgen_ctrl_t;
endpackage

// File: rtl/pwgen_odometer.sv
module pwgen_odometer #(
    parameter int NCHARS = 7,
    parameter int ALPHA  = 26,
    localparam int IDXW  = (ALPHA > 1) ? $clog2(ALPHA) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   step,
    output logic [NCHARS*IDXW-1:0] idx,
    output logic                   last
);
    localparam logic [IDXW-1:0] MAXI = IDXW'(ALPHA - 1);

    logic [IDXW-1:0] dig_d [NCHARS];
    logic [IDXW-1:0] dig_q [NCHARS];

    always_comb begin
        logic carry;
        carry = step;
        last  = 1'b1;
        for (int p = NCHARS - 1; p >= 0; p--) begin
            logic at_max;
            at_max = (dig_q[p] == MAXI);
            last   = last & at_max;
            if (clear)
                dig_d[p] = '0;
            else if (carry)
                dig_d[p] = at_max ? '0 : dig_q[p] + 1'b1;
            else
                dig_d[p] = dig_q[p];
            carry = carry & at_max;
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NCHARS; p++) begin
            if (!rst_n) dig_q[p] <= '0;
            else        dig_q[p] <= dig_d[p];
        end
    end

    always_comb begin
        for (int p = 0; p < NCHARS; p++)
            idx[p*IDXW +: IDXW] = dig_q[p];
    end

    // R3: a step that is not the final wrap always changes the digits
    a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !last) |=> (idx != $past(idx)));
    // R7: stepping past the final digit set returns to all zero
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (idx == '0));
endmodule

// File: rtl/pwgen_packer.sv
module pwgen_packer #(
    parameter int         NCHARS     = 7,
    parameter int         ALPHA      = 26,
    parameter logic [7:0] FIRST_CHAR = 8'h61,
    localparam int IDXW  = (ALPHA > 1) ? $clog2(ALPHA) : 1
) (
    input  logic [NCHARS*IDXW-1:0] idx,
    output logic [511:0]           blk,
    output logic [8*NCHARS-1:0]    cand
);
    localparam logic [63:0] LEN_BITS = 64'(NCHARS * 8);

    for (genvar b = 0; b < 64; b++) begin : g_byte
        if (b < NCHARS) begin : g_char
            logic [7:0] ch;
            assign ch             = FIRST_CHAR + 8'(idx[b*IDXW +: IDXW]);
            assign blk[8*b +: 8]  = ch;
            assign cand[8*b +: 8] = ch;
        end else if (b == NCHARS) begin : g_pad
            assign blk[8*b +: 8] = 8'h80;
        end else if (b >= 56) begin : g_len
            assign blk[8*b +: 8] = LEN_BITS[8*(b-56) +: 8];
        end else begin : g_zero
            assign blk[8*b +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/pwgen_top.sv
module pwgen_top #(
    parameter int         NCHARS     = 7,
    parameter int         ALPHA      = 26,
    parameter logic [7:0] FIRST_CHAR = 8'h61
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                take,
    output logic                blk_valid,
    output logic [511:0]        blk_data,
    output logic [8*NCHARS-1:0] cand,
    output logic                done
);
    import pwgen_pkg::*;

    localparam int IDXW = (ALPHA > 1) ? $clog2(ALPHA) : 1;
    localparam logic [8*NCHARS-1:0] FIRST_CAND = {NCHARS{FIRST_CHAR}};
    localparam logic [8*NCHARS-1:0] LAST_CAND  = {NCHARS{8'(FIRST_CHAR + 8'(ALPHA - 1))}};

    pwgen_ctrl_t ctl_d, ctl_q;
    logic clear_w, step_w, last_w;
    logic [NCHARS*IDXW-1:0] idx_w;

    always_comb begin
        ctl_d   = ctl_q;
        clear_w = 1'b0;
        step_w  = 1'b0;
        if (!ctl_q.running) begin
            if (start) begin
                ctl_d.running = 1'b1;
                ctl_d.done    = 1'b0;
                clear_w       = 1'b1;
            end
        end else if (take) begin
            step_w = 1'b1;
            if (last_w) begin
                ctl_d.running = 1'b0;
                ctl_d.done    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pwgen_odometer #(.NCHARS(NCHARS), .ALPHA(ALPHA)) u_odo (
        .clk(clk), .rst_n(rst_n), .clear(clear_w), .step(step_w),
        .idx(idx_w), .last(last_w)
    );

    pwgen_packer #(.NCHARS(NCHARS), .ALPHA(ALPHA), .FIRST_CHAR(FIRST_CHAR)) u_pack (
        .idx(idx_w), .blk(blk_data), .cand(cand)
    );

    assign blk_valid = ctl_q.running;
    assign done      = ctl_q.done;

    // R4: a held candidate stays put
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !take) |=> (blk_valid && $stable(cand)));
    // R2: start from idle loads the first string
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_valid && start) |=> (blk_valid && !done && cand == FIRST_CAND));
    // R9: idle without start changes nothing
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_valid && !start) |=> (!blk_valid && $stable(cand)));
    // R7: done only follows consumption of the final string
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cand) == LAST_CAND && $past(blk_valid) && $past(take)));
    // R7: valid and done never together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_valid && done));
    // R8: start during a run does not disturb a held candidate
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && start && !take) |=> (blk_valid && $stable(cand)));
endmodule

// File: tb/pwgen_top_test.sv
module pwgen_top_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic st0, tk0, st1, tk1;
    logic         v0, d0, v1, d1;
    logic [511:0] b0, b1;
    logic [55:0]  c0;
    logic [23:0]  c1;

    pwgen_top uut (
        .clk(clk), .rst_n(rst_n), .start(st0), .take(tk0),
        .blk_valid(v0), .blk_data(b0), .cand(c0), .done(d0)
    );
    pwgen_top #(.NCHARS(3), .ALPHA(3)) uut_small (
        .clk(clk), .rst_n(rst_n), .start(st1), .take(tk1),
        .blk_valid(v1), .blk_data(b1), .cand(c1), .done(d1)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int nch [2] = '{7, 3};
    int alp [2] = '{26, 3};
    int md [2][8];
    bit mrun [2];
    bit mdone [2];
    int obs_acc1 = 0;
    bit count_checked = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] exp_blk(int k);
        logic [511:0] r = '0;
        logic [63:0]  len = 64'(nch[k] * 8);
        for (int b = 0; b < nch[k]; b++) r[8*b +: 8] = 8'(97 + md[k][b]);
        r[8*nch[k] +: 8] = 8'h80;
        r[448 +: 64] = len;
        return r;
    endfunction

    function automatic logic [55:0] exp_cand(int k);
        logic [55:0] r = '0;
        for (int b = 0; b < nch[k]; b++) r[8*b +: 8] = 8'(97 + md[k][b]);
        return r;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            mrun[k] = 0; mdone[k] = 0;
            for (int p = 0; p < 8; p++) md[k][p] = 0;
        end
    endtask

    task automatic model_step(int k, bit s, bit t);
        if (!mrun[k]) begin
            if (s) begin
                mrun[k] = 1; mdone[k] = 0;
                for (int p = 0; p < 8; p++) md[k][p] = 0;
            end
        end else if (t) begin
            bit c = 1;
            for (int p = nch[k] - 1; p >= 0 && c; p--) begin
                if (md[k][p] == alp[k] - 1) md[k][p] = 0;
                else begin md[k][p]++; c = 0; end
            end
            if (c) begin mrun[k] = 0; mdone[k] = 1; end
        end
    endtask

    task automatic compare_all(input string tag);
        chk(v0 === mrun[0], tag, "valid", 512'(v0), 512'(mrun[0]));
        chk(d0 === mdone[0], tag, "done", 512'(d0), 512'(mdone[0]));
        chk(b0 === exp_blk(0), "R5", "block", b0, exp_blk(0));
        chk(c0 === exp_cand(0), "R6", "cand", 512'(c0), 512'(exp_cand(0)));
        chk(v1 === mrun[1], tag, "small valid", 512'(v1), 512'(mrun[1]));
        chk(d1 === mdone[1], tag, "small done", 512'(d1), 512'(mdone[1]));
        chk(b1 === exp_blk(1), "R5", "small block", b1, exp_blk(1));
        chk(56'(c1) === exp_cand(1), "R6", "small cand", 512'(c1), 512'(exp_cand(1)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; st0 = 0; tk0 = 0; st1 = 0; tk1 = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        chk(c0 === {7{8'h61}}, "R1", "reset cand", 512'(c0), 512'({7{8'h61}}));
        rst_n = 1;
        for (int t = 0; t < 1000; t++) begin
            string tag;
            // stimulus for the default instance
            tk0 = (t < 6) ? 1'b1 : (t % 9 != 3);   // R9 early, R4 gaps later
            st0 = (t == 6) || (t == 40) || (t == 41);  // R8 at 40/41
            // stimulus for the small instance
            tk1 = (t % 5 != 0);
            st1 = (t == 2) || (t == 10) || (t == 100);
            if (mrun[1] && tk1) obs_acc1++;
            model_step(0, st0, tk0);
            model_step(1, st1, tk1);
            @(negedge clk);
            if (t < 6) tag = "R9";
            else if (t == 6) tag = "R2";
            else if (t == 40 || t == 41) tag = "R8";
            else if (!tk0) tag = "R4";
            else tag = "R3";
            compare_all(tag);
            if (mdone[1] && !count_checked) begin
                count_checked = 1;
                chk(obs_acc1 == 27, "R7", "emitted count", 512'(obs_acc1), 512'(27));
            end
        end
        chk(count_checked, "R7", "small run completed", 512'(count_checked), 512'(1));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule